// File: doc/BRIEF.md
# Header-Aligned Serial-to-Parallel Word Deserializer

This block turns a descrambled serial video bit stream into aligned parallel words. Bits arrive one per clock-enable pulse (`bit_vld`), least significant bit of each word first. A run-length detector watches the stream for the timing reference header that precedes every EAV and SAV code. That header is a word of all ones followed by two words of all zeros. A counter tracks the current run of ones, and a small state machine counts the zeros that follow a long enough run. When the header is recognised, the word-phase divider restarts so that the following words are framed on the header.

The parallel side runs in the same clock domain. `word_stb` is a one-cycle enable that marks a new `word_out` once per `WORD_W` accepted bits, so the word rate is one tenth of the bit rate in the default build. Each recognised header flips the level of `hdr_tgl`. A downstream consumer therefore detects a header by comparing that output with its previous value.

A header that falls on the current word boundary leaves the running output untouched. A header that falls anywhere else restarts the framing at once and drops the partly assembled word.

Top module: `hdr_align_deser`

## Requirements
- R1: After reset `word_stb` and `hdr_tgl` are low, and the first word is framed on the first accepted bit after reset.
- R2: Each word holds `WORD_W` consecutive accepted bits, with the earliest bit in bit 0. `word_stb` is high for exactly the one cycle after the clock edge that accepts the last bit of the word.
- R3: Clock edges with `bit_vld` low have no effect, whatever the value of `bit_in`.
- R4: A header is recognised when at least `ONES_MIN` (default 10) consecutive ones are followed by `ZEROS_LEN` (default 20) consecutive zeros. `hdr_tgl` changes level after the edge that accepts the last of those zeros, and it changes at no other time.
- R5: A run of fewer than `ONES_MIN` ones followed by `ZEROS_LEN` zeros is not recognised.
- R6: A one that arrives before the `ZEROS_LEN`-th zero abandons the match, so no recognition takes place.
- R7: After a recognition, the next word emitted consists of the `WORD_W` bits that immediately follow the header (the XYZ word), complete, with its first bit in bit 0.
- R8: When the header ends on the current word boundary, every word is emitted as before, including the final all-zero header word, and the framing does not change.
- R9: When the header ends off the current word boundary, the partly assembled word is discarded, with no strobe, and framing restarts after the header.
- R10: `word_stb` never stays high for two consecutive cycles. It is raised only for words completed under R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Bit enable; `bit_in` is taken only when high |
| bit_in | input | 1 | Descrambled serial data bit |
| word_out | output | WORD_W | Aligned parallel word, earliest bit in bit 0 |
| word_stb | output | 1 | One-cycle strobe marking a new `word_out` |
| hdr_tgl | output | 1 | Flips level on every recognised header |

## Verification
The bench builds the block with its default parameters: 10-bit words, a run of at least 10 ones, and exactly 20 zeros. With those values every word-phase offset of a header can be swept in one short run. Headers are inserted after slips of 0 through 9 bits, which places the header end at every phase of the divider. Both the aligned path (R8) and the discard path (R9) are exercised repeatedly. Near-miss patterns test the two abort rules: nine ones followed by twenty zeros, and ten ones followed by nineteen zeros. Random `bit_vld` gaps carrying junk data test R3. Every emitted word is compared with slices of the sent stream, which the bench computes arithmetically from the header end positions.

// File: rtl/hdr_align_pkg.sv
package hdr_align_pkg;

   typedef enum logic [0:0] {
      SEEK_ONES  = 1'b0,
      COUNT_ZERO = 1'b1
   } seek_state_t;

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/hdr_run_counter.sv
module hdr_run_counter #(
   parameter int ONES_MIN = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_in,
   input  logic force_clr,
   output logic ones_ok
);
   import hdr_align_pkg::*;

   localparam int CW = cnt_width(ONES_MIN);
   localparam logic [CW-1:0] SAT = CW'(ONES_MIN);

   logic [CW-1:0] run_cnt;

   generate
      if (ONES_MIN < 2) begin : g_bad_ones
         $error("hdr_run_counter: ONES_MIN must be at least 2");
      end
   endgenerate

   // Active-low clear driven by the data itself, or forced by the controller.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (bit_vld) begin
         if (!bit_in || force_clr) begin
            run_cnt <= '0;
         end else if (run_cnt != SAT) begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

   assign ones_ok = (run_cnt == SAT);

   // R5: an accepted zero always breaks the run of ones
   assert_zero_breaks_run_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && !bit_in) |=> !ones_ok);

endmodule

// File: rtl/hdr_seq_fsm.sv
module hdr_seq_fsm #(
   parameter int ZEROS_LEN = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_in,
   input  logic ones_ok,
   output logic hdr_hit,
   output logic run_clr
);
   import hdr_align_pkg::*;

   localparam int ZW = cnt_width(ZEROS_LEN);
   localparam logic [ZW-1:0] ZLAST = ZW'(ZEROS_LEN - 1);

   seek_state_t   state;
   logic [ZW-1:0] zero_cnt;

   generate
      if (ZEROS_LEN < 2) begin : g_bad_zeros
         $error("hdr_seq_fsm: ZEROS_LEN must be at least 2");
      end
   endgenerate

   assign hdr_hit = (state == COUNT_ZERO) && bit_vld && !bit_in && (zero_cnt == ZLAST);
   // The controller holds the run counter in reset only on the detecting bit.
   assign run_clr = hdr_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SEEK_ONES;
         zero_cnt <= '0;
      end else if (bit_vld) begin
         unique case (state)
            SEEK_ONES: begin
               if (!bit_in && ones_ok) begin
                  state    <= COUNT_ZERO;
                  zero_cnt <= ZW'(1);
               end
            end
            COUNT_ZERO: begin
               if (bit_in || hdr_hit) begin
                  state    <= SEEK_ONES;
                  zero_cnt <= '0;
               end else begin
                  zero_cnt <= zero_cnt + 1'b1;
               end
            end
            default: begin
               state    <= SEEK_ONES;
               zero_cnt <= '0;
            end
         endcase
      end
   end

   // R6: a one while counting zeros abandons the match
   assert_one_aborts_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == COUNT_ZERO && bit_vld && bit_in) |=> (state == SEEK_ONES));

   // R4: the zero count never passes the header length
   assert_zero_bound_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      zero_cnt <= ZLAST);

endmodule

// File: rtl/hdr_word_framer.sv
module hdr_word_framer #(
   parameter int WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              bit_in,
   input  logic              hdr_hit,
   output logic [WORD_W-1:0] word_out,
   output logic              word_stb
);
   localparam int PW = $clog2(WORD_W);
   localparam logic [PW-1:0] PLAST = PW'(WORD_W - 1);

   logic [PW-1:0]     phase;
   logic [WORD_W-2:0] hold;
   logic [WORD_W-1:0] assembled;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("hdr_word_framer: WORD_W must be at least 2");
      end
   endgenerate

   // First received bit ends up in bit 0 after WORD_W shifts.
   assign assembled = {bit_in, hold};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= '0;
         hold     <= '0;
         word_out <= '0;
         word_stb <= 1'b0;
      end else begin
         word_stb <= 1'b0;
         if (bit_vld) begin
            hold <= assembled[WORD_W-1:1];
            if (phase == PLAST) begin
               word_out <= assembled;
               word_stb <= 1'b1;
               phase    <= '0;
            end else if (hdr_hit) begin
               phase <= '0;
            end else begin
               phase <= phase + 1'b1;
            end
         end
      end
   end

   // R9: a header off the word boundary produces no strobe
   assert_misalign_drop_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && hdr_hit && phase != PLAST) |=> !word_stb);

   // R10: strobes are never back to back
   assert_no_back_to_back_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> !word_stb);

   // R3: a strobe always follows an accepted bit
   assert_stb_after_bit_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |-> $past(bit_vld));

endmodule

// File: rtl/hdr_align_deser.sv
module hdr_align_deser #(
   parameter int WORD_W    = 10,
   parameter int ONES_MIN  = 10,
   parameter int ZEROS_LEN = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word_out,
   output logic              word_stb,
   output logic              hdr_tgl
);
   logic ones_ok;
   logic hdr_hit;
   logic run_clr;

   hdr_run_counter #(.ONES_MIN(ONES_MIN)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld   (bit_vld),
      .bit_in    (bit_in),
      .force_clr (run_clr),
      .ones_ok   (ones_ok)
   );

   hdr_seq_fsm #(.ZEROS_LEN(ZEROS_LEN)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_vld (bit_vld),
      .bit_in  (bit_in),
      .ones_ok (ones_ok),
      .hdr_hit (hdr_hit),
      .run_clr (run_clr)
   );

   hdr_word_framer #(.WORD_W(WORD_W)) u_frm (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (bit_vld),
      .bit_in   (bit_in),
      .hdr_hit  (hdr_hit),
      .word_out (word_out),
      .word_stb (word_stb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr_tgl <= 1'b0;
      end else if (hdr_hit) begin
         hdr_tgl <= ~hdr_tgl;
      end
   end

   // R4: the level flips only on the edge after a recognised header
   assert_tgl_on_hit_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_tgl != $past(hdr_tgl)) |-> $past(hdr_hit));

endmodule

// File: tb/hdr_align_deser_tb.sv
module hdr_align_deser_tb;
   localparam int W    = 10;
   localparam int OM   = 10;
   localparam int ZL   = 20;
   localparam int MAXB = 4096;
   localparam int MAXW = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_vld = 1'b0;
   logic bit_in = 1'b0;
   logic [W-1:0] word_out;
   logic word_stb;
   logic hdr_tgl;

   always #5 clk = ~clk;

   hdr_align_deser #(.WORD_W(W), .ONES_MIN(OM), .ZEROS_LEN(ZL)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (bit_vld),
      .bit_in   (bit_in),
      .word_out (word_out),
      .word_stb (word_stb),
      .hdr_tgl  (hdr_tgl)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic sent [MAXB];
   int nbits = 0;
   int hdr_end [64];
   int nhdr = 0;
   logic [W-1:0] got [MAXW];
   int ngot = 0;
   int ntgl = 0;
   logic prev_stb = 1'b0;
   logic prev_tgl = 1'b0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Output monitor, sampled away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (word_stb) begin
            if (ngot < MAXW) got[ngot] = word_out;
            ngot++;
            chk(!prev_stb, "R10 strobe not back to back", int'(prev_stb), 0);
         end
         if (hdr_tgl != prev_tgl) ntgl++;
         prev_stb = word_stb;
         prev_tgl = hdr_tgl;
      end
   end

   task automatic push_bit(input logic b);
      if ($urandom_range(0, 3) == 0) begin
         repeat ($urandom_range(1, 3)) begin
            bit_vld = 1'b0;
            bit_in  = 1'($urandom_range(0, 1));
            @(negedge clk);
         end
      end
      bit_vld = 1'b1;
      bit_in  = b;
      if (nbits < MAXB) sent[nbits] = b;
      nbits++;
      @(negedge clk);
      bit_vld = 1'b0;
      bit_in  = 1'($urandom_range(0, 1));
   endtask

   task automatic push_word(input logic [W-1:0] w);
      for (int i = 0; i < W; i++) push_bit(w[i]);
   endtask

   function automatic logic [W-1:0] rand_word();
      return W'($urandom_range(4, 1019));
   endfunction

   task automatic push_header();
      push_word(10'h3FF);
      push_word(10'h000);
      push_word(10'h000);
      hdr_end[nhdr] = nbits - 1;
      nhdr++;
      chk(hdr_tgl == nhdr[0], "R4 toggle after header", int'(hdr_tgl), nhdr % 2);
      push_word(rand_word());
   endtask

   task automatic push_stray(input int n);
      logic v;
      v = 1'($urandom_range(0, 1));
      for (int i = 0; i < n; i++) begin
         push_bit(v);
         v = ~v;
      end
   endtask

   task automatic push_short_ones();
      logic t0;
      t0 = hdr_tgl;
      push_bit(1'b0);
      repeat (OM - 1) push_bit(1'b1);
      repeat (ZL) push_bit(1'b0);
      chk(hdr_tgl == t0, "R5 short run of ones not recognised", int'(hdr_tgl), int'(t0));
      push_bit(1'b1);
   endtask

   task automatic push_early_one();
      logic t0;
      t0 = hdr_tgl;
      push_bit(1'b0);
      repeat (OM) push_bit(1'b1);
      repeat (ZL - 1) push_bit(1'b0);
      push_bit(1'b1);
      chk(hdr_tgl == t0, "R6 early one aborts match", int'(hdr_tgl), int'(t0));
   endtask

   initial begin
      int s;
      int lim;
      int ex;
      logic [W-1:0] e;
      string tag;

      repeat (5) @(negedge clk);
      chk(word_stb == 1'b0, "R1 strobe low in reset", int'(word_stb), 0);
      chk(hdr_tgl == 1'b0, "R1 toggle low in reset", int'(hdr_tgl), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(word_stb == 1'b0, "R1 strobe low after reset", int'(word_stb), 0);

      repeat (4) push_word(rand_word());
      push_header();                       // aligned (R8)
      repeat (3) push_word(rand_word());
      push_header();                       // aligned again (R8)
      for (int off = 1; off < W; off++) begin
         push_stray(off);                  // misaligned (R9)
         repeat (2) push_word(rand_word());
         push_header();
         repeat (2) push_word(rand_word());
      end
      push_short_ones();
      repeat (2) push_word(rand_word());
      push_header();
      push_word(rand_word());
      push_stray(3);
      push_early_one();
      repeat (2) push_word(rand_word());
      push_header();
      repeat (3) push_word(rand_word());
      repeat (4) @(negedge clk);

      // Expected words: slices of the sent stream, restarted after each header end.
      ex = 0;
      for (int sg = 0; sg <= nhdr; sg++) begin
         s   = (sg == 0) ? 0 : hdr_end[sg-1] + 1;
         lim = (sg < nhdr) ? hdr_end[sg] : nbits - 1;
         tag = (sg == 0) ? "R1 R2 R3 word before first header"
                         : "R2 R3 R7 R8 R9 word after header";
         while (s + W - 1 <= lim) begin
            for (int i = 0; i < W; i++) e[i] = sent[s + i];
            if (ex < ngot && ex < MAXW) begin
               chk(got[ex] == e, $sformatf("%s seg %0d idx %0d", tag, sg, ex),
                   int'(got[ex]), int'(e));
            end
            ex++;
            s += W;
         end
      end
      chk(ngot == ex, "R9 R10 number of words emitted", ngot, ex);
      chk(ntgl == nhdr, "R4 R5 R6 number of toggles", ntgl, nhdr);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule